// File: doc/BRIEF.md
# Load/Store Address and Base-Writeback Sequencer

This block produces the memory addresses and the register indices for load and store transfers. It also produces the updated base-register value that the register file writes back. A single transfer moves one 32-bit word. It has three indexing choices:
- access at base plus offset with the base left alone;
- access at base plus offset and write that sum back;
- access at the plain base and write base plus offset back afterwards.

A multiple transfer walks a 16-bit register mask. It moves one word per cycle at ascending word addresses. Its first address is either the base itself (increment-after) or the next word up (increment-before).

A request is presented on the input pins with a one-cycle `start` while the block is idle. The block copies the request into its own state, so later input changes have no effect until it is idle again. The transfers then appear on consecutive cycles with `xfer_valid` high. A one-cycle `done` follows, carrying the writeback value on `wb_value` and its enable on `wb_valid`.

Top module: `xfer_addr_seq`

## Requirements
- R1: After reset, and while reset is held, `busy`, `done`, `xfer_valid` and `wb_valid` are 0. A reset in the middle of a request drops all of them at once.
- R2: A single transfer with `idx_mode` 0 makes one transfer at `base + offset` with `xfer_reg` equal to `single_reg`, and `wb_valid` stays 0. Code 3 behaves the same as code 0.
- R3: A single transfer with `idx_mode` 1 makes one transfer at `base + offset`, and at `done` it raises `wb_valid` with `wb_value = base + offset`.
- R4: A single transfer with `idx_mode` 2 makes one transfer at the unmodified `base`, and at `done` it raises `wb_valid` with `wb_value = base + offset`.
- R5: `offset` is a two's complement value. A negative offset subtracts, and all address sums wrap modulo 2^32.
- R6: A multiple transfer with `inc_before` = 0 uses `base` as its first address and adds 4 for each later register.
- R7: A multiple transfer with `inc_before` = 1 uses `base + 4` as its first address and adds 4 for each later register.
- R8: In a multiple transfer, the registers whose `reg_list` bit is 1 are issued in ascending index order on `xfer_reg`. The lowest index gets the lowest address.
- R9: At the end of a multiple transfer, `wb_value` is `base + 4 * (number of ones in reg_list)`. `wb_valid` equals the `list_wb` input given at start.
- R10: A `start` taken while idle yields its first transfer in the next cycle. There is one transfer per cycle with `busy` high during exactly those cycles, then `done` high for exactly one cycle.
- R11: A multiple transfer with an all-zero `reg_list` makes no transfer. It raises `done` in the cycle after `start`, with `wb_value = base`.
- R12: `start` is ignored while `busy` or `done` is high. Input changes during that time do not alter the running transfer sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| start | input | 1 | Request strobe, taken only when idle |
| multi | input | 1 | 1: register-list transfer, 0: single transfer |
| idx_mode | input | 2 | Single indexing: 0 offset, 1 pre-index with writeback, 2 post-index, 3 as 0 |
| inc_before | input | 1 | List transfer: 1 starts at base+4, 0 starts at base |
| list_wb | input | 1 | List transfer: request base writeback |
| base | input | 32 | Base register value |
| offset | input | 32 | Signed offset for single transfers |
| reg_list | input | 16 | Register mask for list transfers |
| single_reg | input | 4 | Register index for a single transfer |
| busy | output | 1 | High on every transfer cycle |
| done | output | 1 | One-cycle completion pulse |
| xfer_valid | output | 1 | A word transfer is issued this cycle |
| xfer_addr | output | 32 | Byte address of the current word |
| xfer_reg | output | 4 | Register index of the current word |
| wb_valid | output | 1 | Base writeback enable, only with `done` |
| wb_value | output | 32 | New base value, valid with `done` |

## Verification
If the pending mask is corrupted, a register is repeated or skipped on `xfer_reg`. The count of transfer cycles is then wrong before `done` arrives. A wrong address counter shows on `xfer_addr` in the same cycle as the bad beat, and every later beat is offset by the same amount. A writeback sum or enable latched wrongly at `start` stays hidden until the single `done` cycle. A control state that does not return to idle shows as a missing or stretched `done`, or as a `start` that is not taken one cycle after completion.

// File: rtl/xfer_seq_pkg.sv
package xfer_seq_pkg;

   typedef enum logic [1:0] {
      IDX_OFFSET  = 2'd0,
      IDX_PRE_WB  = 2'd1,
      IDX_POST_WB = 2'd2,
      IDX_RSVD    = 2'd3
   } idx_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_XFER = 2'd1,
      ST_DONE = 2'd2
   } seq_state_e;

endpackage

// File: rtl/xfer_single_calc.sv
module xfer_single_calc
   import xfer_seq_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [1:0]        mode,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] offset,
   output logic [ADDR_W-1:0] acc_addr,
   output logic [ADDR_W-1:0] new_base,
   output logic              wb_en
);
   idx_mode_e   mode_e;
   logic [ADDR_W-1:0] sum;

   assign mode_e = idx_mode_e'(mode);
   assign sum    = base + offset;   // two's complement wraps naturally

   always_comb begin
      new_base = sum;
      unique case (mode_e)
         IDX_PRE_WB: begin
            acc_addr = sum;
            wb_en    = 1'b1;
         end
         IDX_POST_WB: begin
            acc_addr = base;
            wb_en    = 1'b1;
         end
         default: begin             // offset mode and the spare code
            acc_addr = sum;
            wb_en    = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/xfer_list_walker.sv
module xfer_list_walker #(
   parameter int ADDR_W     = 32,
   parameter int NREG       = 16,
   parameter int WORD_BYTES = 4,
   localparam int REG_W     = $clog2(NREG),
   localparam int CNT_W     = $clog2(NREG + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              advance,
   input  logic [NREG-1:0]   list_in,
   input  logic [ADDR_W-1:0] base_in,
   input  logic              inc_before,
   output logic [REG_W-1:0]  cur_reg,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              last_beat,
   output logic              list_empty,
   output logic [CNT_W-1:0]  list_count
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

   logic [NREG-1:0] pend_q;
   logic [NREG-1:0] below_empty;
   logic [NREG-1:0] low_oh;

   // per-bit "nothing pending below me" terms
   for (genvar g = 0; g < NREG; g++) begin : g_prio
      if (g == 0) begin : g_first
         assign below_empty[g] = 1'b1;
      end else begin : g_rest
         assign below_empty[g] = ~|pend_q[g-1:0];
      end
   end

   assign low_oh    = pend_q & below_empty;
   assign last_beat = ~|(pend_q & ~low_oh);
   assign list_empty = ~|list_in;

   always_comb begin
      cur_reg = '0;
      for (int i = 0; i < NREG; i++)
         if (low_oh[i]) cur_reg = cur_reg | REG_W'(i);
   end

   always_comb begin
      list_count = '0;
      for (int i = 0; i < NREG; i++)
         list_count = list_count + CNT_W'(list_in[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q   <= '0;
         cur_addr <= '0;
      end else if (load) begin
         pend_q   <= list_in;
         cur_addr <= inc_before ? base_in + STEP : base_in;
      end else if (advance) begin
         pend_q   <= pend_q & ~low_oh;
         cur_addr <= cur_addr + STEP;
      end
   end

   // registers leave in strictly rising index order
   AST_REG_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
      advance && !last_beat |=> cur_reg > $past(cur_reg)) else $error("order"); // R8

endmodule

// File: rtl/xfer_seq_fsm.sv
module xfer_seq_fsm
   import xfer_seq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic req_multi,
   input  logic req_empty,
   input  logic run_multi,
   input  logic last_beat,
   output logic accept,
   output logic busy,
   output logic done
);
   seq_state_e state_q, state_d;

   assign accept = start && (state_q == ST_IDLE);
   assign busy   = (state_q == ST_XFER);
   assign done   = (state_q == ST_DONE);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (accept) state_d = (req_multi && req_empty) ? ST_DONE : ST_XFER;
         ST_XFER: if (!run_multi || last_beat) state_d = ST_DONE;
         ST_DONE: state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && !busy) else $error("done width"); // R10
   AST_BUSY_ENDS_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> busy || done) else $error("busy exit"); // R10

endmodule

// File: rtl/xfer_addr_seq.sv
module xfer_addr_seq #(
   parameter int ADDR_W     = 32,
   parameter int NREG       = 16,
   parameter int WORD_BYTES = 4,
   localparam int REG_W     = $clog2(NREG),
   localparam int CNT_W     = $clog2(NREG + 1),
   localparam int STEP_SH   = $clog2(WORD_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              multi,
   input  logic [1:0]        idx_mode,
   input  logic              inc_before,
   input  logic              list_wb,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] offset,
   input  logic [NREG-1:0]   reg_list,
   input  logic [REG_W-1:0]  single_reg,
   output logic              busy,
   output logic              done,
   output logic              xfer_valid,
   output logic [ADDR_W-1:0] xfer_addr,
   output logic [REG_W-1:0]  xfer_reg,
   output logic              wb_valid,
   output logic [ADDR_W-1:0] wb_value
);
   initial begin
      assert (WORD_BYTES > 0 && (WORD_BYTES & (WORD_BYTES - 1)) == 0)
         else $error("WORD_BYTES must be a power of two");
      assert (NREG >= 2) else $error("NREG too small");
      assert (ADDR_W > STEP_SH + CNT_W) else $error("ADDR_W too narrow");
   end

   logic              accept;
   logic              last_beat, list_empty;
   logic [CNT_W-1:0]  list_count;
   logic [REG_W-1:0]  walk_reg;
   logic [ADDR_W-1:0] walk_addr;
   logic [ADDR_W-1:0] s_addr, s_new_base;
   logic              s_wb_en;

   logic              multi_q, wb_en_q;
   logic [ADDR_W-1:0] s_addr_q, wb_val_q;
   logic [REG_W-1:0]  s_reg_q;

   xfer_single_calc #(.ADDR_W(ADDR_W)) u_single (
      .mode(idx_mode), .base(base), .offset(offset),
      .acc_addr(s_addr), .new_base(s_new_base), .wb_en(s_wb_en)
   );

   xfer_list_walker #(.ADDR_W(ADDR_W), .NREG(NREG), .WORD_BYTES(WORD_BYTES)) u_walk (
      .clk(clk), .rst_n(rst_n),
      .load(accept && multi), .advance(busy && multi_q),
      .list_in(reg_list), .base_in(base), .inc_before(inc_before),
      .cur_reg(walk_reg), .cur_addr(walk_addr),
      .last_beat(last_beat), .list_empty(list_empty), .list_count(list_count)
   );

   xfer_seq_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .start(start),
      .req_multi(multi), .req_empty(list_empty),
      .run_multi(multi_q), .last_beat(last_beat),
      .accept(accept), .busy(busy), .done(done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         multi_q  <= 1'b0;
         wb_en_q  <= 1'b0;
         s_addr_q <= '0;
         s_reg_q  <= '0;
         wb_val_q <= '0;
      end else if (accept) begin
         multi_q  <= multi;
         s_addr_q <= s_addr;
         s_reg_q  <= single_reg;
         if (multi) begin
            wb_val_q <= base + (ADDR_W'(list_count) << STEP_SH);
            wb_en_q  <= list_wb;
         end else begin
            wb_val_q <= s_new_base;
            wb_en_q  <= s_wb_en;
         end
      end
   end

   assign xfer_valid = busy;
   assign xfer_addr  = multi_q ? walk_addr : s_addr_q;
   assign xfer_reg   = multi_q ? walk_reg  : s_reg_q;
   assign wb_valid   = done && wb_en_q;
   assign wb_value   = wb_val_q;

   AST_WB_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> done) else $error("wb outside done"); // R9
   AST_SINGLE_ONE_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid && !multi_q |=> done) else $error("single length"); // R2
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid && multi_q |=> !xfer_valid || xfer_addr == $past(xfer_addr) + ADDR_W'(WORD_BYTES))
      else $error("address step"); // R6
   AST_IDLE_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy && !done && !multi |=> xfer_valid) else $error("start lost"); // R10

endmodule

// File: tb/xfer_addr_seq_bench.sv
`timescale 1ns/1ps
module xfer_addr_seq_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, multi = 1'b0, inc_before = 1'b0, list_wb = 1'b0;
   logic [1:0]  idx_mode = 2'd0;
   logic [31:0] base = '0, offset = '0;
   logic [15:0] reg_list = '0;
   logic [3:0]  single_reg = '0;
   logic        busy, done, xfer_valid, wb_valid;
   logic [31:0] xfer_addr, wb_value;
   logic [3:0]  xfer_reg;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;   // 125 MHz

   xfer_addr_seq u_xfer_addr_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .multi(multi), .idx_mode(idx_mode),
      .inc_before(inc_before), .list_wb(list_wb), .base(base), .offset(offset),
      .reg_list(reg_list), .single_reg(single_reg), .busy(busy), .done(done),
      .xfer_valid(xfer_valid), .xfer_addr(xfer_addr), .xfer_reg(xfer_reg),
      .wb_valid(wb_valid), .wb_value(wb_value)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // vector table: multi, mode, inc_before, list_wb, base, offset, list, single_reg
   localparam int NV = 9;
   localparam logic        V_MUL [NV] = '{0, 0, 0, 0, 0, 1, 1, 1, 1};
   localparam logic [1:0]  V_MOD [NV] = '{0, 1, 2, 1, 3, 0, 0, 0, 0};
   localparam logic        V_IB  [NV] = '{0, 0, 0, 0, 0, 0, 1, 0, 1};
   localparam logic        V_WB  [NV] = '{0, 0, 0, 0, 0, 1, 1, 0, 1};
   localparam logic [31:0] V_BAS [NV] = '{32'h9000, 32'h9000, 32'h9000, 32'h100, 32'h40,
                                          32'h80010, 32'h80010, 32'h200, 32'hFFFF_FFF0};
   localparam logic [31:0] V_OFF [NV] = '{32'h4, 32'h4, 32'h4, 32'hFFFF_FFF8, 32'h10,
                                          32'h0, 32'h0, 32'h0, 32'h0};
   localparam logic [15:0] V_LST [NV] = '{16'h0, 16'h0, 16'h0, 16'h0, 16'h0,
                                          16'h000E, 16'h000E, 16'h8001, 16'hFFFF};
   localparam logic [3:0]  V_SRG [NV] = '{4'd0, 4'd3, 4'd7, 4'd9, 4'd15, 4'd0, 4'd0, 4'd0, 4'd0};

   // Runs one request; expectations come from the requirements alone.
   task automatic run_op(input logic m, input logic [1:0] md, input logic ib, input logic wb,
                         input logic [31:0] b, input logic [31:0] o, input logic [15:0] l,
                         input logic [3:0] sr, input bit poke, input string tag);
      logic [31:0] e_addr [16];
      logic [3:0]  e_reg  [16];
      int          n = 0;
      logic        e_wb;
      logic [31:0] e_wbv;
      if (!m) begin
         e_addr[0] = (md == 2'd2) ? b : b + o;
         e_reg[0]  = sr;
         n         = 1;
         e_wb      = (md == 2'd1) || (md == 2'd2);
         e_wbv     = b + o;
      end else begin
         logic [31:0] a = ib ? b + 32'd4 : b;
         for (int i = 0; i < 16; i++) if (l[i]) begin
            e_addr[n] = a; e_reg[n] = 4'(i); n++; a = a + 32'd4;
         end
         e_wb  = wb;
         e_wbv = b + 32'(4 * n);
      end
      @(negedge clk);
      multi = m; idx_mode = md; inc_before = ib; list_wb = wb;
      base = b; offset = o; reg_list = l; single_reg = sr; start = 1'b1;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         start = poke;
         if (poke) begin base = 32'hDEAD_0000; offset = 32'h100; reg_list = 16'h00F0; inc_before = ~ib; end
         chk(xfer_valid && busy && !done, {tag, " R10 beat valid"}, {29'd0, xfer_valid, busy, done}, 32'd6);
         chk(xfer_addr == e_addr[k], {tag, " R6/R7/R2 address"}, xfer_addr, e_addr[k]);
         chk(xfer_reg == e_reg[k], {tag, " R8 register"}, {28'd0, xfer_reg}, {28'd0, e_reg[k]});
      end
      @(negedge clk);
      start = poke;
      chk(done && !xfer_valid && !busy, {tag, " R10 done"}, {30'd0, done, xfer_valid}, 32'd2);
      chk(wb_valid == e_wb, {tag, " R9 wb_valid"}, {31'd0, wb_valid}, {31'd0, e_wb});
      if (e_wb) chk(wb_value == e_wbv, {tag, " R9 wb_value"}, wb_value, e_wbv);
      @(negedge clk);
      chk(!done && !busy && !xfer_valid, {tag, " R12 idle after done"}, {30'd0, done, busy}, 32'd0);
      start = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!busy && !done && !xfer_valid && !wb_valid, "R1 reset state",
          {28'd0, busy, done, xfer_valid, wb_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !xfer_valid && !wb_valid, "R1 after release",
          {28'd0, busy, done, xfer_valid, wb_valid}, 32'd0);

      // table walk: R2 R3 R4 R5 R6 R7 R8 R9
      for (int v = 0; v < NV; v++)
         run_op(V_MUL[v], V_MOD[v], V_IB[v], V_WB[v], V_BAS[v], V_OFF[v], V_LST[v], V_SRG[v],
                1'b0, $sformatf("vec%0d", v));

      // R11: empty list completes next cycle, base unchanged
      @(negedge clk);
      multi = 1'b1; reg_list = 16'h0; base = 32'h1234_5670; list_wb = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(done && !xfer_valid && !busy, "R11 empty done", {30'd0, done, xfer_valid}, 32'd2);
      chk(wb_value == 32'h1234_5670, "R11 empty base kept", wb_value, 32'h1234_5670);
      @(negedge clk);
      chk(!done && !xfer_valid, "R11 empty no transfer", {30'd0, done, xfer_valid}, 32'd0);

      // R12: starts and input changes while running are ignored
      run_op(1'b1, 2'd0, 1'b0, 1'b1, 32'h80010, 32'h0, 16'h000E, 4'd0, 1'b1, "R12 list poke");
      run_op(1'b0, 2'd2, 1'b0, 1'b0, 32'h5000, 32'h20, 16'h0, 4'd5, 1'b1, "R12 single poke");

      // R1: reset in the middle of a list transfer
      @(negedge clk);
      multi = 1'b1; reg_list = 16'h00FF; base = 32'h0; inc_before = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(xfer_valid, "R1 pre-reset running", {31'd0, xfer_valid}, 32'd1);
      rst_n = 1'b0;
      #1;
      chk(!busy && !done && !xfer_valid && !wb_valid, "R1 mid-op reset",
          {28'd0, busy, done, xfer_valid, wb_valid}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      run_op(1'b0, 2'd1, 1'b0, 1'b0, 32'h10, 32'h8, 16'h0, 4'd2, 1'b0, "R3 after reset");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule